// File: doc/BRIEF.md
# External Interrupt Trigger Unit

This unit takes six asynchronous interrupt pins from outside the chip and gives the interrupt controller one request line per pin. Each pin first passes through a two-flop synchroniser. It then goes to a per-pin channel that applies the trigger mode software has chosen for that pin. The modes are rising edge, falling edge, either edge, active-high level, active-low level, or off.

Each channel is a small state machine with three states:

- `CH_IDLE`: nothing is pending.
- `CH_EDGE_HELD`: an edge event was captured and is held until software clears it.
- `CH_LEVEL_ON`: a level mode sees its active level.

The transitions are:

- *capture*: IDLE to EDGE_HELD, on an edge event in an edge mode.
- *sw_clear*: EDGE_HELD to IDLE, on a clear write with no event in the same cycle.
- *level_assert*: IDLE to LEVEL_ON, when the level is active in a level mode.
- *level_release*: LEVEL_ON to IDLE, when the level goes inactive or the channel leaves level mode.
- *retarget*: EDGE_HELD to LEVEL_ON or to IDLE, when the mode changes.
- *disarm*: any state to IDLE, when the mode is off.

The pending flag of a pin is high in every state except `CH_IDLE`.

A 32-bit register port holds four registers, addressed by byte offset with `reg_addr[3:2]` decoded:

- a mode register at 0x0, with one 4-bit field per pin;
- a spare storage word at 0x4;
- the pending register at 0x8;
- the enable register at 0xC.

Writes are synchronous. Reads return data combinationally. Each interrupt output is the pending flag of its pin gated by the pin's enable bit.

Top module: `exti_trigger_unit`

## Requirements
- R1: After reset, every register reads 0, every channel is idle and `irq_out` is all zero.
- R2: A pin change driven before clock edge k appears at `irq_out` just after edge k+2 and not earlier: two synchroniser stages plus the pending register.
- R3: The mode register at offset 0x0 gives pin i the field in bits [4i+3:4i]. Bits 31:24 are not stored and read as 0.
- R4: Mode 1 captures a 0-to-1 transition, mode 2 a 1-to-0 transition and mode 3 either transition. A captured event keeps the pin pending after the pin returns, until software clears it.
- R5: In mode 5 the pending flag equals the synchronised pin level. In mode 6 it equals the inverse. A level pending flag drops on its own when the level goes inactive.
- R6: Mode codes 0, 4 and 7 to 15 capture nothing, and they clear a flag that is already pending on the next edge.
- R7: The pending register at 0x8 shows pin i in bit i, with bits 31:6 reading 0. Writing 0 to bit i clears a held edge event of pin i. Writing 1 leaves it unchanged. An edge event in the same cycle as the clear wins. A clear does not affect a level-mode pin.
- R8: The enable register at 0xC gates pin i's output with bit i. While a pin is disabled its pending flag is still recorded and is readable.
- R9: Offset 0x4 is a 32-bit read/write word with no effect on detection or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_pin | input | 6 | Asynchronous external interrupt pins |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq_out | output | 6 | Per-pin interrupt requests |

## Verification
If a channel were left in the wrong state, its `irq_out` bit and pending bit 0x8 would differ from the expected value on the very next cycle for an enabled pin. The same goes for an edge held after a clear and for a level flag that fails to release. A wrong synchroniser depth shows up as a one-cycle shift of every transition against the three-edge latency. A mis-stored mode or enable bit shows up on the next read of its register and on the first pin event that the bit governs.

// File: rtl/exti_pkg.sv
package exti_pkg;

    localparam int MODE_W = 4;

    typedef enum logic [1:0] {
        CH_IDLE,
        CH_EDGE_HELD,
        CH_LEVEL_ON
    } ch_state_e;

    typedef enum logic [2:0] {
        TRIG_OFF,
        TRIG_RISE,
        TRIG_FALL,
        TRIG_BOTH,
        TRIG_HIGH,
        TRIG_LOW
    } trig_kind_e;

    localparam logic [MODE_W-1:0] CODE_RISE = 4'd1;
    localparam logic [MODE_W-1:0] CODE_FALL = 4'd2;
    localparam logic [MODE_W-1:0] CODE_BOTH = 4'd3;
    localparam logic [MODE_W-1:0] CODE_HIGH = 4'd5;
    localparam logic [MODE_W-1:0] CODE_LOW  = 4'd6;

    function automatic trig_kind_e decode_mode(input logic [MODE_W-1:0] code);
        trig_kind_e k;
        case (code)
            CODE_RISE: k = TRIG_RISE;
            CODE_FALL: k = TRIG_FALL;
            CODE_BOTH: k = TRIG_BOTH;
            CODE_HIGH: k = TRIG_HIGH;
            CODE_LOW:  k = TRIG_LOW;
            default:   k = TRIG_OFF;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/exti_sync.sv
module exti_sync #(
    parameter int WIDTH  = 6,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stg[s] <= '0;
        end else begin
            stg[0] <= din;
            for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
        end
    end

    assign dout = stg[STAGES-1];

    // R2
    sync_first_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stg[0] == $past(din));

endmodule

// File: rtl/exti_channel.sv
module exti_channel
    import exti_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lvl,
    input  logic [MODE_W-1:0] mode,
    input  logic              clr_req,
    output logic              pending
);
    ch_state_e  state_q, state_d;
    trig_kind_e kind;
    logic       prev_q;
    logic       edge_mode, level_mode, lvl_act, event_hit;

    always_comb begin
        kind       = decode_mode(mode);
        edge_mode  = (kind == TRIG_RISE) || (kind == TRIG_FALL) || (kind == TRIG_BOTH);
        level_mode = (kind == TRIG_HIGH) || (kind == TRIG_LOW);
        lvl_act    = (kind == TRIG_HIGH) ? lvl : ((kind == TRIG_LOW) ? !lvl : 1'b0);
        case (kind)
            TRIG_RISE: event_hit = lvl & ~prev_q;
            TRIG_FALL: event_hit = ~lvl & prev_q;
            TRIG_BOTH: event_hit = lvl ^ prev_q;
            default:   event_hit = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= lvl;
    end

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (!edge_mode && !level_mode) begin
            state_d = CH_IDLE;
        end else if (level_mode) begin
            state_d = lvl_act ? CH_LEVEL_ON : CH_IDLE;
        end else begin
            unique case (state_q)
                CH_IDLE:      state_d = event_hit ? CH_EDGE_HELD : CH_IDLE;
                CH_EDGE_HELD: state_d = (event_hit || !clr_req) ? CH_EDGE_HELD : CH_IDLE;
                CH_LEVEL_ON:  state_d = event_hit ? CH_EDGE_HELD : CH_IDLE;
                default:      state_d = CH_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CH_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_IDLE:      pending = 1'b0;
            CH_EDGE_HELD: pending = 1'b1;
            CH_LEVEL_ON:  pending = 1'b1;
            default:      pending = 1'b0;
        endcase
    end

    // R6
    off_mode_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_mode && !level_mode) |=> !pending);

    // R4
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_EDGE_HELD && edge_mode && !clr_req) |=> pending);

    // R5
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> pending == $past(lvl_act));

    // R7
    sw_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && !event_hit && clr_req) |=> !pending);

endmodule

// File: rtl/exti_regs.sv
module exti_regs
    import exti_pkg::*;
#(
    parameter int NPINS  = 6,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    reg_wr,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [DATA_W-1:0]       reg_wdata,
    input  logic [NPINS-1:0]        pending,
    output logic [DATA_W-1:0]       reg_rdata,
    output logic [NPINS*MODE_W-1:0] cfg_q,
    output logic [NPINS-1:0]        en_q,
    output logic [NPINS-1:0]        clr_req
);
    localparam int CFG_W = NPINS * MODE_W;
    localparam logic [1:0] SEL_CFG  = 2'd0;
    localparam logic [1:0] SEL_AUX  = 2'd1;
    localparam logic [1:0] SEL_PEND = 2'd2;
    localparam logic [1:0] SEL_EN   = 2'd3;

    logic [1:0]        sel;
    logic [DATA_W-1:0] aux_q;

    assign sel = reg_addr[3:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
            aux_q <= '0;
            en_q  <= '0;
        end else if (reg_wr) begin
            case (sel)
                SEL_CFG: cfg_q <= reg_wdata[CFG_W-1:0];
                SEL_AUX: aux_q <= reg_wdata;
                SEL_EN:  en_q  <= reg_wdata[NPINS-1:0];
                default: ;
            endcase
        end
    end

    assign clr_req = (reg_wr && sel == SEL_PEND) ? ~reg_wdata[NPINS-1:0] : '0;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            SEL_CFG:  reg_rdata[CFG_W-1:0] = cfg_q;
            SEL_AUX:  reg_rdata            = aux_q;
            SEL_PEND: reg_rdata[NPINS-1:0] = pending;
            SEL_EN:   reg_rdata[NPINS-1:0] = en_q;
            default:  reg_rdata            = '0;
        endcase
    end

    // R8
    en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_EN) |=> en_q == $past(reg_wdata[NPINS-1:0]));

    // R3
    cfg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && sel == SEL_CFG) |=> cfg_q == $past(reg_wdata[CFG_W-1:0]));

    // R9
    aux_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_wr && sel == SEL_AUX) |=> $stable(aux_q));

endmodule

// File: rtl/exti_trigger_unit.sv
module exti_trigger_unit
    import exti_pkg::*;
#(
    parameter int NPINS       = 6,
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  ext_pin,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NPINS-1:0]  irq_out
);
    localparam int CFG_W = NPINS * MODE_W;

    logic [NPINS-1:0] pin_sync, pend, en, clr;
    logic [CFG_W-1:0] cfg;

    exti_sync #(.WIDTH(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_pin),
        .dout (pin_sync)
    );

    exti_regs #(.NPINS(NPINS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_wr   (reg_wr),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .pending  (pend),
        .reg_rdata(reg_rdata),
        .cfg_q    (cfg),
        .en_q     (en),
        .clr_req  (clr)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_ch
        exti_channel u_ch (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl    (pin_sync[i]),
            .mode   (cfg[i*MODE_W +: MODE_W]),
            .clr_req(clr[i]),
            .pending(pend[i])
        );
    end

    assign irq_out = pend & en;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0) || rst_n);

endmodule

// File: tb/exti_trigger_unit_tb.sv
`timescale 1ns/1ps
module exti_trigger_unit_tb_top;
    localparam int N = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [N-1:0] ext_pin = '0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [N-1:0] irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    exti_trigger_unit dut_i (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    // ---- reference model built from the requirements ----
    logic [N-1:0] m_s1, m_s2, m_prev, m_en;
    logic [23:0]  m_cfg;
    int           m_st [N];   // 0 idle, 1 held edge, 2 level active

    function automatic int next_st(int st, logic [3:0] code, logic cur, logic old, logic clr);
        logic ev;
        case (code)
            4'd1: ev = cur & ~old;
            4'd2: ev = ~cur & old;
            4'd3: ev = cur ^ old;
            4'd5: return cur ? 2 : 0;
            4'd6: return !cur ? 2 : 0;
            default: return 0;
        endcase
        if (ev) return 1;
        if (st == 1 && !clr) return 1;
        return 0;
    endfunction

    function automatic logic [N-1:0] m_pend();
        logic [N-1:0] p;
        for (int i = 0; i < N; i++) p[i] = (m_st[i] != 0);
        return p;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_en = '0; m_cfg = '0;
            for (int i = 0; i < N; i++) m_st[i] = 0;
        end else begin
            for (int i = 0; i < N; i++)
                m_st[i] = next_st(m_st[i], m_cfg[4*i +: 4], m_s2[i], m_prev[i],
                                  reg_wr && reg_addr == 4'h8 && !reg_wdata[i]);
            m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
            if (reg_wr && reg_addr == 4'h0) m_cfg = reg_wdata[23:0];
            if (reg_wr && reg_addr == 4'hC) m_en  = reg_wdata[N-1:0];
        end
    end

    // ---- helpers ----
    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [3:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(logic [3:0] a, output logic [31:0] d);
        reg_addr = a; #0.1; d = reg_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] r;
        void'($urandom(32'h1a2b3c4d));
        step(3);
        rst_n = 1'b1;
        step(1);
        // R1 reset state
        check("R1 irq", {26'd0, irq_out}, 32'h0);
        rd(4'h0, r); check("R1 cfg", r, 0);
        rd(4'h4, r); check("R1 aux", r, 0);
        rd(4'h8, r); check("R1 pend", r, 0);
        rd(4'hC, r); check("R1 en", r, 0);
        // R9 spare word
        wr(4'h4, 32'hA5A5_0F0F);
        rd(4'h4, r); check("R9 aux readback", r, 32'hA5A5_0F0F);
        check("R9 no irq", {26'd0, irq_out}, 0);
        // R3 field storage, upper bits dropped
        wr(4'h0, 32'hFFFF_FFFF);
        rd(4'h0, r); check("R3 cfg width", r, 32'h00FF_FFFF);
        // R4 rising on pin0 with R2 latency
        wr(4'h0, 32'h0000_0001);
        wr(4'hC, 32'h0000_003F);
        ext_pin[0] = 1'b1;
        step(2); check("R2 not before third edge", {26'd0, irq_out}, 0);
        step(1); check("R2 R4 rise captured", {26'd0, irq_out}, 32'h1);
        ext_pin[0] = 1'b0;
        step(4); check("R4 rise held", {26'd0, irq_out}, 32'h1);
        wr(4'h8, 32'hFFFF_FFFF);
        check("R7 write one keeps", {26'd0, irq_out}, 32'h1);
        wr(4'h8, 32'hFFFF_FFFE);
        check("R7 write zero clears", {26'd0, irq_out}, 0);
        // R4 falling on pin1
        wr(4'h0, 32'h0000_0020);
        ext_pin[1] = 1'b1; step(4);
        check("R4 fall ignores rise", {26'd0, irq_out}, 0);
        ext_pin[1] = 1'b0; step(3);
        check("R4 fall captured", {26'd0, irq_out}, 32'h2);
        // R4 both edges on pin2
        wr(4'h0, 32'h0000_0300);
        wr(4'h8, 32'h0);
        ext_pin[2] = 1'b1; step(3);
        check("R4 both rise", {26'd0, irq_out}, 32'h4);
        wr(4'h8, 32'hFFFF_FFFB);
        check("R7 clear pin2", {26'd0, irq_out}, 0);
        ext_pin[2] = 1'b0; step(3);
        check("R4 both fall", {26'd0, irq_out}, 32'h4);
        rd(4'h8, r); check("R7 pending read", r, 32'h4);
        // R6 code 4 disarms and clears
        wr(4'h0, 32'h0000_0400);
        step(1); check("R6 code4 clears", {26'd0, irq_out}, 0);
        ext_pin[2] = 1'b1; step(3);
        check("R6 code4 no capture", {26'd0, irq_out}, 0);
        // R5 high level on pin3
        wr(4'h0, 32'h0000_5000);
        ext_pin[3] = 1'b1; step(3);
        check("R5 high asserts", {26'd0, irq_out}, 32'h8);
        ext_pin[3] = 1'b0; step(3);
        check("R5 high releases", {26'd0, irq_out}, 0);
        // R5 low level on pin4
        wr(4'h0, 32'h0006_0000);
        step(1); check("R5 low asserts", {26'd0, irq_out}, 32'h10);
        ext_pin[4] = 1'b1; step(3);
        check("R5 low releases", {26'd0, irq_out}, 0);
        ext_pin[4] = 1'b0; step(3);
        wr(4'h8, 32'h0);
        check("R7 clear ignored in level", {26'd0, irq_out}, 32'h10);
        // R8 enable gating
        wr(4'hC, 32'h0);
        check("R8 gated off", {26'd0, irq_out}, 0);
        rd(4'h8, r); check("R8 pending kept", r, 32'h10);
        wr(4'hC, 32'h3F);
        check("R8 regated", {26'd0, irq_out}, 32'h10);
        // R6 code 9 on pin5
        wr(4'h0, 32'h0090_0000);
        ext_pin[5] = 1'b1; step(4);
        rd(4'h8, r); check("R6 code9 no pending", r, 0);
        // R7 event wins over same-cycle clear
        wr(4'h0, 32'h0000_0001);
        ext_pin[0] = 1'b1; step(2);
        wr(4'h8, 32'h0);
        check("R7 event beats clear", {26'd0, irq_out}, 32'h1);
        // random phase against model
        for (int c = 0; c < 4000; c++) begin
            check("R4 R5 R6 R7 R8 random", {26'd0, irq_out}, {26'd0, m_pend() & m_en});
            for (int i = 0; i < N; i++)
                if ($urandom_range(3) == 0) ext_pin[i] = ~ext_pin[i];
            reg_wr = 1'b0; reg_wdata = '0;
            case ($urandom_range(15))
                0: begin
                    logic [23:0] v;
                    for (int i = 0; i < N; i++)
                        v[4*i +: 4] = ($urandom_range(3) == 0) ? 4'($urandom_range(15))
                                                                 : 4'($urandom_range(6));
                    reg_wr = 1'b1; reg_addr = 4'h0; reg_wdata = {8'd0, v};
                end
                1: begin reg_wr = 1'b1; reg_addr = 4'hC; reg_wdata = $urandom; end
                2, 3: begin reg_wr = 1'b1; reg_addr = 4'h8; reg_wdata = $urandom; end
                default: reg_addr = 4'h8;
            endcase
            @(negedge clk);
        end
        reg_wr = 1'b0;
        finish_run();
    end
endmodule